// File: doc/BRIEF.md
# Aliased Control Register Bank

This block is a small bank of control registers that sits behind a bus front end. The front end presents a 32-bit byte address, a 4-bit byte-enable mask, a 32-bit write word and a one-cycle write-valid strobe. The bank compares the address against the address of every register view and produces one write strobe per stored register. It also returns a 32-bit read word through a purely combinational multiplexer.

The bank holds three kinds of register:
- a single register;
- a register array whose elements sit at a base address plus index times stride;
- a register reachable through two addresses, a primary and an alias. Each of these two views exposes a different subset of the stored fields.

A read word is the stored bits of the fields that are readable through the selected view, each in its own bit position. Every other bit reads as zero. Write-only fields and unused bit positions therefore always read as zero. The stored contents are driven out on a flat vector so that hardware can consume them.

Top module: `csrb_bank`

## Requirements
- R1: While `rst_n` is low and after its release, the storage holds its reset values. With the default parameters these are: single register `0x0090005A`, each array element `0x00001234`, aliased register `0xF0000003`.
- R2: With the default parameters the views decode as follows. The single register is at `0x00`. Array element i is at `0x10 + 4*i` for i = 0 and 1. The aliased register's primary view is at `0x20` and its alias at `0x24`. No other address selects any register.
- R3: Storage changes only on the rising clock edge that follows a cycle with `wr_vld` high and a matching address. When `wr_vld` is low, the storage holds.
- R4: A write updates byte b (bits 8b+7..8b) of the writable fields only when `byte_en[b]` is 1.
- R5: The 4-bit read-only field at bits [23:20] of the single register ignores writes and always reads its reset value (default 0x9).
- R6: The write-only field at bits [15:8] of the single register stores written data and shows it on `reg_out`, but reads as zero. The read-write field at bits [7:0] reads back its stored value.
- R7: Bit positions not covered by a readable field read as zero. These are bits [31:24] and [19:16] of the single register, and bits [23:16] of array elements. Array fields sit at [15:0] and [31:24].
- R8: The aliased register stores fields at [3:0], [19:8] and [31:28]. A read at the primary address returns [3:0] and [19:8], with [31:28] as zero. A read at the alias address returns [3:0] and [31:28], with [19:8] as zero.
- R9: A write through either the primary or the alias address updates all writable fields of the same aliased storage.
- R10: An address that selects no view reads as all zeros, and a write to it changes no storage.
- R11: `rd_data` follows `addr` within the same cycle, independent of the clock and of `wr_vld`.
- R12: A write to one array element leaves every other element unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_vld | input | 1 | Write request valid for this cycle |
| addr | input | 32 | Byte address of the access |
| byte_en | input | 4 | Per-byte write enable |
| wr_data | input | 32 | Write word |
| rd_data | output | 32 | Combinational read word for `addr` |
| reg_out | output | 32*(ARR_LEN+2) | Stored words, element 0 (single) in the lowest 32 bits, then array elements, then the aliased register |

## Verification
The bench sweeps every mapped address, every unmapped word address in the decoded range and a few misaligned or far addresses. For each, it tries all sixteen byte-enable patterns. After each write it reads every view back and compares the result against a model that keeps its own masks.

A design that decoded the alias into the wrong field set would leak the [19:8] or [31:28] bits through the wrong address. One that wrote through only the primary view would miss R9. A stride or index mistake would corrupt the neighbouring array element. Ignoring a byte enable, or letting the read-only field be written, shows up as a `reg_out` mismatch on the very next check. Misaligned addresses such as `0x01` and `0x11` catch decoders that drop low address bits.

// File: rtl/csrb_pkg.sv
package csrb_pkg;

    localparam int DW  = 32;
    localparam int BEW = DW / 8;

    typedef logic [DW-1:0] word_t;

    function automatic word_t span(input int msb, input int lsb);
        word_t m;
        m = '0;
        for (int i = 0; i < DW; i++) begin
            if (i >= lsb && i <= msb) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Field layout of the single register: ctl [7:0] rw, key [15:8] wo, ver [23:20] ro
    localparam word_t WM_SINGLE = span(15, 0);
    localparam word_t RM_SINGLE = span(7, 0) | span(23, 20);

    // Array element: lo [15:0] rw, hi [31:24] rw
    localparam word_t WM_ARRAY  = span(15, 0) | span(31, 24);
    localparam word_t RM_ARRAY  = WM_ARRAY;

    // Aliased register: mode [3:0], cnt [19:8], tag [31:28], all rw
    localparam word_t WM_DUAL     = span(3, 0) | span(19, 8) | span(31, 28);
    localparam word_t RM_DUAL_PRI = span(3, 0) | span(19, 8);
    localparam word_t RM_DUAL_ALT = span(3, 0) | span(31, 28);

    // Element order: 0 single, 1..arr_len array, arr_len+1 aliased
    function automatic word_t elem_wmask(input int e, input int arr_len);
        if (e == 0)       return WM_SINGLE;
        if (e <= arr_len) return WM_ARRAY;
        return WM_DUAL;
    endfunction

    // View order: 0 single, 1..arr_len array, arr_len+1 primary, arr_len+2 alias
    function automatic int view_elem(input int v, input int arr_len);
        if (v == 0)       return 0;
        if (v <= arr_len) return v;
        return arr_len + 1;
    endfunction

    function automatic word_t view_rmask(input int v, input int arr_len);
        if (v == 0)           return RM_SINGLE;
        if (v <= arr_len)     return RM_ARRAY;
        if (v == arr_len + 1) return RM_DUAL_PRI;
        return RM_DUAL_ALT;
    endfunction

endpackage

// File: rtl/csrb_decode.sv
module csrb_decode
    import csrb_pkg::*;
#(
    parameter int          ARR_LEN       = 2,
    parameter logic [31:0] SINGLE_ADDR   = 32'h00,
    parameter logic [31:0] ARR_BASE      = 32'h10,
    parameter logic [31:0] ARR_STRIDE    = 32'h4,
    parameter logic [31:0] DUAL_ADDR     = 32'h20,
    parameter logic [31:0] DUAL_ALT_ADDR = 32'h24,
    localparam int         N_ELEM        = ARR_LEN + 2,
    localparam int         N_VIEW        = ARR_LEN + 3
) (
    input  logic [31:0]       addr,
    input  logic              wr_vld,
    output logic [N_VIEW-1:0] view_hit,
    output logic [N_ELEM-1:0] wr_stb
);

    localparam int PRI_V = ARR_LEN + 1;
    localparam int ALT_V = ARR_LEN + 2;

    assign view_hit[0]     = (addr == SINGLE_ADDR);
    assign view_hit[PRI_V] = (addr == DUAL_ADDR);
    assign view_hit[ALT_V] = (addr == DUAL_ALT_ADDR);

    for (genvar i = 0; i < ARR_LEN; i++) begin : g_arr
        localparam logic [31:0] EL_ADDR = ARR_BASE + 32'(i) * ARR_STRIDE;
        assign view_hit[1+i] = (addr == EL_ADDR);
        assign wr_stb[1+i]   = wr_vld && view_hit[1+i];
    end

    assign wr_stb[0]        = wr_vld && view_hit[0];
    assign wr_stb[N_ELEM-1] = wr_vld && (view_hit[PRI_V] || view_hit[ALT_V]);

endmodule

// File: rtl/csrb_store.sv
module csrb_store
    import csrb_pkg::*;
#(
    parameter int                    ARR_LEN = 2,
    localparam int                   N_ELEM  = ARR_LEN + 2,
    parameter logic [N_ELEM*DW-1:0]  RST_VEC = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_ELEM-1:0]            wr_stb,
    input  logic [BEW-1:0]               byte_en,
    input  logic [DW-1:0]                wr_data,
    output logic [N_ELEM-1:0][DW-1:0]    elem_q
);

    typedef struct packed {
        logic [N_ELEM-1:0][DW-1:0] word;
    } bank_t;

    bank_t st_d, st_q;
    word_t bmask;

    always_comb begin
        bmask = '0;
        for (int b = 0; b < BEW; b++) begin
            bmask[8*b +: 8] = {8{byte_en[b]}};
        end
    end

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < N_ELEM; e++) begin
            if (wr_stb[e]) begin
                st_d.word[e] = (st_q.word[e] & ~(elem_wmask(e, ARR_LEN) & bmask))
                             | (wr_data   &  (elem_wmask(e, ARR_LEN) & bmask));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= RST_VEC;
        end else begin
            st_q <= st_d;
        end
    end

    assign elem_q = st_q.word;

endmodule

// File: rtl/csrb_rdmux.sv
module csrb_rdmux
    import csrb_pkg::*;
#(
    parameter int  ARR_LEN = 2,
    localparam int N_ELEM  = ARR_LEN + 2,
    localparam int N_VIEW  = ARR_LEN + 3
) (
    input  logic [N_VIEW-1:0]         view_hit,
    input  logic [N_ELEM-1:0][DW-1:0] elem_q,
    output logic [DW-1:0]             rd_data
);

    always_comb begin
        rd_data = '0;
        for (int v = 0; v < N_VIEW; v++) begin
            if (view_hit[v]) begin
                rd_data = rd_data | (elem_q[view_elem(v, ARR_LEN)] & view_rmask(v, ARR_LEN));
            end
        end
    end

endmodule

// File: rtl/csrb_bank.sv
module csrb_bank
    import csrb_pkg::*;
#(
    parameter int          ARR_LEN       = 2,
    parameter logic [31:0] SINGLE_ADDR   = 32'h00,
    parameter logic [31:0] ARR_BASE      = 32'h10,
    parameter logic [31:0] ARR_STRIDE    = 32'h4,
    parameter logic [31:0] DUAL_ADDR     = 32'h20,
    parameter logic [31:0] DUAL_ALT_ADDR = 32'h24,
    parameter logic [7:0]  RST_CTL       = 8'h5A,
    parameter logic [3:0]  RST_VER       = 4'h9,
    parameter logic [15:0] RST_ARR_LO    = 16'h1234,
    parameter logic [7:0]  RST_ARR_HI    = 8'h00,
    parameter logic [3:0]  RST_MODE      = 4'h3,
    parameter logic [11:0] RST_CNT       = 12'h000,
    parameter logic [3:0]  RST_TAG       = 4'hF,
    localparam int         N_ELEM        = ARR_LEN + 2,
    localparam int         N_VIEW        = ARR_LEN + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_vld,
    input  logic [31:0]          addr,
    input  logic [3:0]           byte_en,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    output logic [N_ELEM*32-1:0] reg_out
);

    localparam word_t RST_SINGLE = {8'h00, RST_VER, 12'h000, RST_CTL};
    localparam word_t RST_ARRAY  = {RST_ARR_HI, 8'h00, RST_ARR_LO};
    localparam word_t RST_DUAL   = {RST_TAG, 8'h00, RST_CNT, 4'h0, RST_MODE};
    localparam logic [N_ELEM*DW-1:0] RST_VEC = {RST_DUAL, {ARR_LEN{RST_ARRAY}}, RST_SINGLE};

    logic [N_VIEW-1:0]         view_hit;
    logic [N_ELEM-1:0]         wr_stb;
    logic [N_ELEM-1:0][DW-1:0] elem_q;

    csrb_decode #(
        .ARR_LEN      (ARR_LEN),
        .SINGLE_ADDR  (SINGLE_ADDR),
        .ARR_BASE     (ARR_BASE),
        .ARR_STRIDE   (ARR_STRIDE),
        .DUAL_ADDR    (DUAL_ADDR),
        .DUAL_ALT_ADDR(DUAL_ALT_ADDR)
    ) u_decode (
        .addr    (addr),
        .wr_vld  (wr_vld),
        .view_hit(view_hit),
        .wr_stb  (wr_stb)
    );

    csrb_store #(
        .ARR_LEN(ARR_LEN),
        .RST_VEC(RST_VEC)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .byte_en(byte_en),
        .wr_data(wr_data),
        .elem_q (elem_q)
    );

    csrb_rdmux #(
        .ARR_LEN(ARR_LEN)
    ) u_rdmux (
        .view_hit(view_hit),
        .elem_q  (elem_q),
        .rd_data (rd_data)
    );

    assign reg_out = elem_q;

endmodule

// File: rtl/csrb_bank_chk.sv
module csrb_bank_chk #(
    parameter int          ARR_LEN       = 2,
    parameter logic [31:0] SINGLE_ADDR   = 32'h00,
    parameter logic [31:0] DUAL_ADDR     = 32'h20,
    parameter logic [31:0] DUAL_ALT_ADDR = 32'h24,
    localparam int         N_ELEM        = ARR_LEN + 2,
    localparam int         N_VIEW        = ARR_LEN + 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_vld,
    input logic [31:0]          addr,
    input logic [31:0]          rd_data,
    input logic [N_ELEM*32-1:0] reg_out,
    input logic [N_VIEW-1:0]    view_hit,
    input logic [N_ELEM-1:0]    wr_stb
);

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb)); // R2

    AST_STB_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |-> (wr_stb == '0)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> $stable(reg_out)); // R3

    AST_RO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(reg_out[23:20])); // R5

    AST_WO_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SINGLE_ADDR) |-> (rd_data[15:8] == 8'h00)); // R6

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SINGLE_ADDR) |-> (rd_data[31:24] == 8'h00 && rd_data[19:16] == 4'h0)); // R7

    AST_PRI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == DUAL_ADDR) |-> (rd_data[31:20] == 12'h000 && rd_data[7:4] == 4'h0)); // R8

    AST_ALT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == DUAL_ALT_ADDR) |-> (rd_data[27:4] == 24'h0)); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (view_hit == '0) |-> (rd_data == 32'h0)); // R10

endmodule

bind csrb_bank csrb_bank_chk #(
    .ARR_LEN      (ARR_LEN),
    .SINGLE_ADDR  (SINGLE_ADDR),
    .DUAL_ADDR    (DUAL_ADDR),
    .DUAL_ALT_ADDR(DUAL_ALT_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_vld  (wr_vld),
    .addr    (addr),
    .rd_data (rd_data),
    .reg_out (reg_out),
    .view_hit(view_hit),
    .wr_stb  (wr_stb)
);

// File: tb/test_csrb_bank.sv
`timescale 1ns/1ps
module test_csrb_bank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_vld = 1'b0;
    logic [31:0]  addr = '0;
    logic [3:0]   byte_en = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic [127:0] reg_out;

    int errors = 0;
    int checks = 0;
    logic [31:0] mdl [4];

    always #4 clk = ~clk;

    csrb_bank i_csrb_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_vld (wr_vld),
        .addr   (addr),
        .byte_en(byte_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .reg_out(reg_out)
    );

    function automatic int elem_of(logic [31:0] a);
        case (a)
            32'h00:         return 0;
            32'h10:         return 1;
            32'h14:         return 2;
            32'h20, 32'h24: return 3;
            default:        return -1;
        endcase
    endfunction

    function automatic logic [31:0] wmask_of(int e);
        if (e == 0) return 32'h0000FFFF;
        if (e == 3) return 32'hF00FFF0F;
        return 32'hFF00FFFF;
    endfunction

    function automatic logic [31:0] rmask_of(logic [31:0] a);
        case (a)
            32'h00:         return 32'h00F000FF;
            32'h10, 32'h14: return 32'hFF00FFFF;
            32'h20:         return 32'h000FFF0F;
            32'h24:         return 32'hF000000F;
            default:        return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [31:0] a);
        case (a)
            32'h00:         return "R6";
            32'h10, 32'h14: return "R7";
            32'h20, 32'h24: return "R8";
            default:        return "R10";
        endcase
    endfunction

    function automatic string wtag_of(logic [31:0] a);
        case (a)
            32'h00:         return "R4";
            32'h10, 32'h14: return "R12";
            32'h20, 32'h24: return "R9";
            default:        return "R10";
        endcase
    endfunction

    function automatic logic [31:0] addr_at(int k);
        if (k < 12)  return 32'(k * 4);
        if (k == 12) return 32'h01;
        if (k == 13) return 32'h11;
        return 32'hFFFF_FF20;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_store(string tag);
        for (int e = 0; e < 4; e++) begin
            check(tag, reg_out[e*32 +: 32], mdl[e], $sformatf("reg_out element %0d", e));
        end
    endtask

    task automatic read_chk(logic [31:0] a, string tag);
        int e;
        logic [31:0] exp;
        addr = a;
        wr_vld = 1'b0;
        #1;
        e = elem_of(a);
        exp = (e < 0) ? 32'h0 : (mdl[e] & rmask_of(a));
        check(tag, rd_data, exp, $sformatf("read @%h", a));
    endtask

    task automatic do_write(logic [31:0] a, logic [31:0] d, logic [3:0] be, logic vld, string tag);
        int e;
        logic [31:0] m;
        @(negedge clk);
        addr = a; wr_data = d; byte_en = be; wr_vld = vld;
        @(negedge clk);
        wr_vld = 1'b0;
        e = elem_of(a);
        if (vld && e >= 0) begin
            m = wmask_of(e) & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            mdl[e] = (mdl[e] & ~m) | (d & m);
        end
        #1;
        check_store(tag);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mdl[0] = 32'h0090005A;
        mdl[1] = 32'h00001234;
        mdl[2] = 32'h00001234;
        mdl[3] = 32'hF0000003;

        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        check_store("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_store("R1");
        for (int k = 0; k < 15; k++) read_chk(addr_at(k), "R1");

        // R2: decode of every view
        read_chk(32'h10, "R2");
        read_chk(32'h14, "R2");
        read_chk(32'h24, "R2");
        read_chk(32'h18, "R2");

        // R3: request without valid leaves storage alone
        do_write(32'h00, 32'hFFFF_FFFF, 4'hF, 1'b0, "R3");
        do_write(32'h24, 32'h0000_0000, 4'hF, 1'b0, "R3");

        // R11: read follows the address mid-cycle
        @(posedge clk);
        #2;
        read_chk(32'h20, "R11");
        read_chk(32'h00, "R11");

        // Sweep: every address, every byte-enable pattern
        for (int k = 0; k < 15; k++) begin
            for (int be = 0; be < 16; be++) begin
                do_write(addr_at(k),
                         32'hA5C3_0F96 ^ (32'(k) * 32'h0101_0101) ^ (32'(be) * 32'h1111_0011),
                         4'(be), 1'b1, wtag_of(addr_at(k)));
            end
            for (int j = 0; j < 15; j++) read_chk(addr_at(j), tag_of(addr_at(j)));
        end

        // R5: read-only field survives all-ones writes
        do_write(32'h00, 32'hFFFF_FFFF, 4'hF, 1'b1, "R5");
        addr = 32'h00;
        #1;
        check("R5", {28'h0, rd_data[23:20]}, 32'h9, "read-only field");

        // R9: alias write seen through primary, and back
        do_write(32'h24, 32'h6ABC_DEF1, 4'hF, 1'b1, "R9");
        read_chk(32'h20, "R9");
        do_write(32'h20, 32'h1234_5678, 4'hF, 1'b1, "R9");
        read_chk(32'h24, "R9");

        // R12: element 1 write keeps element 0
        do_write(32'h14, 32'h0000_0000, 4'hF, 1'b1, "R12");
        read_chk(32'h10, "R12");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule